// File: doc/BRIEF.md
# Host-Configured Crosspoint Switch Matrix

This block routes sixteen single-bit input lanes onto sixteen single-bit output lanes. Every output takes its value from exactly one input, chosen by a 4-bit select field kept for that output; sixteen such fields form the routing map, 64 bits in all. Data moves only from inputs to outputs. The selection itself is combinational: each output is an AND-OR of the inputs, gated by a one-hot decode of its field.

A host changes the map in one of two ways. It can write one output's field directly: an address names the output and the data names the input. The same address reads that field back. It can also stream a whole new map through one serial loader that all outputs share. One field enters per clock. A busy flag stays high for the sixteen clocks of the load. The old map keeps driving the outputs for that whole time, and the new map replaces it in one step when the last field is taken.

Top module: `xpoint_matrix`

## Requirements
- R1: After reset every select field is 0, so every output bit equals input bit 0, and every readback returns 0.
- R2: Output bit o equals input bit s at all times, where s is the active select field of output o. The path is combinational, with no clock between `din` and `dout`.
- R3: When `host_we` is 1 and `ld_busy` is 0 at a rising edge, the field of output `host_addr` takes `host_wdata`. From the next cycle on, both `dout` and `host_rdata` reflect the new value.
- R4: `host_rdata` always shows the active select field of the output named by `host_addr`.
- R5: A 1 on `ld_start` at an idle rising edge raises `ld_busy` for exactly 16 cycles. `ld_field` is sampled at each of the 16 edges that see `ld_busy` high. The k-th sample, counting from 0, becomes the field of output k.
- R6: While `ld_busy` is high, the active map, `dout` routing and readback all keep the previous map. The full new map takes effect at the edge that takes the 16th sample, and `ld_busy` falls at that same edge.
- R7: Host writes made while `ld_busy` is high are ignored. They change neither the active map nor the loaded result.
- R8: A 1 on `ld_start` while `ld_busy` is high is ignored. The load in progress neither restarts nor extends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 16 | Input lanes |
| dout | output | 16 | Output lanes, each routed from one input |
| host_we | input | 1 | Host write strobe for one select field |
| host_addr | input | 4 | Output index for host write and readback |
| host_wdata | input | 4 | Input index to store for the addressed output |
| host_rdata | output | 4 | Active select field of the addressed output |
| ld_start | input | 1 | Starts a serial reload of the whole map |
| ld_field | input | 4 | Serial field stream, one field per clock, output 0 first |
| ld_busy | output | 1 | High while a serial reload is in progress |

## Verification
Clocked assertions check several things on every cycle. They check that every output bit equals the input named by its active field. They check that the map cannot move while a load is running, except at its final edge. They check that each busy period ends after exactly sixteen samples and that an idle host write lands at the addressed field. Other behaviour needs the bench's scenarios. These include the reset map, the serial field order that places the k-th sample on output k, the way the whole new map appears at once, and the fact that writes and restart requests made during a load leave no trace in the loaded result. Randomised writes and input patterns, compared against a bench model of the map, cover the routing across many maps.

// File: rtl/xpoint_matrix.sv
module xpoint_matrix #(
  parameter int N_IN  = 16,
  parameter int N_OUT = 16
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [N_IN-1:0]                       din,
  output logic [N_OUT-1:0]                      dout,
  input  logic                                  host_we,
  input  logic [((N_OUT > 1) ? $clog2(N_OUT) : 1)-1:0] host_addr,
  input  logic [((N_IN > 1) ? $clog2(N_IN) : 1)-1:0]   host_wdata,
  output logic [((N_IN > 1) ? $clog2(N_IN) : 1)-1:0]   host_rdata,
  input  logic                                  ld_start,
  input  logic [((N_IN > 1) ? $clog2(N_IN) : 1)-1:0]   ld_field,
  output logic                                  ld_busy
);
  localparam int SW = (N_IN > 1) ? $clog2(N_IN) : 1;
  localparam int AW = (N_OUT > 1) ? $clog2(N_OUT) : 1;
  localparam logic [AW-1:0] LAST = AW'(N_OUT - 1);

  logic [N_OUT-1:0][SW-1:0] map_q, shadow_q, shifted;
  logic [AW-1:0]            cnt_q;
  logic                     busy_q;
  logic                     addr_ok;

  assign addr_ok = int'(host_addr) < N_OUT;

  always_comb begin
    for (int i = 0; i < N_OUT - 1; i++) shifted[i] = shadow_q[i+1];
    shifted[N_OUT-1] = ld_field;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q    <= '0;
      shadow_q <= '0;
      cnt_q    <= '0;
      busy_q   <= 1'b0;
    end else if (busy_q) begin
      shadow_q <= shifted;
      if (cnt_q == LAST) begin
        map_q  <= shifted;
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      if (host_we && addr_ok) map_q[host_addr] <= host_wdata;
      if (ld_start) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end
  end

  assign ld_busy    = busy_q;
  assign host_rdata = addr_ok ? map_q[host_addr] : '0;

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic [N_IN-1:0] hot;
    assign hot     = N_IN'(1) << map_q[o];
    assign dout[o] = |(din & hot);

    assert_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
      dout[o] == din[map_q[o]]);
  end

  assert_hold_map_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(map_q));

  assert_interval_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(cnt_q) == LAST));

  assert_idle_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && !busy_q && addr_ok) |=> (map_q[$past(host_addr)] == $past(host_wdata)));

  assert_busy_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && busy_q && cnt_q != LAST) |=> $stable(map_q));

  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && ld_start && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: tb/tb_xpoint_matrix.sv
`timescale 1ns/1ps
module tb_xpoint_matrix;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic        host_we = 0;
  logic [3:0]  host_addr = '0, host_wdata = '0, host_rdata;
  logic        ld_start = 0;
  logic [3:0]  ld_field = '0;
  logic        ld_busy;

  int total = 0, bad = 0;
  logic [3:0] mdl [16];
  logic [3:0] nmap [16];

  always #5 clk = ~clk;

  xpoint_matrix dut (.clk, .rst_n, .din, .dout, .host_we, .host_addr, .host_wdata,
                     .host_rdata, .ld_start, .ld_field, .ld_busy);

  function automatic logic [15:0] exp_out(logic [15:0] d);
    logic [15:0] r;
    for (int o = 0; o < 16; o++) r[o] = d[mdl[o]];
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_map(string req);
    for (int a = 0; a < 16; a++) begin
      host_addr = 4'(a);
      #1 chk(req, host_rdata, mdl[a]);
    end
  endtask

  // serial reload; optionally inject host writes and a second start while busy
  task automatic do_load(bit inject);
    for (int k = 0; k < 16; k++) nmap[k] = 4'($urandom_range(15));
    @(negedge clk);
    host_we = 0; ld_start = 1;
    @(negedge clk);
    ld_start = 0;
    chk("R5 busy after start", ld_busy, 1);
    for (int k = 0; k < 16; k++) begin
      ld_field = nmap[k];
      din = 16'($urandom);
      if (inject) begin
        host_we = 1; host_addr = 4'(k); host_wdata = ~nmap[k];
        ld_start = (k == 5);
      end
      #1 chk("R6 old routing during load", dout, exp_out(din));
      if (!inject) chk("R6 old readback during load", host_rdata, mdl[host_addr]);
      @(negedge clk);
      host_we = 0; ld_start = 0;
      if (k < 15) chk("R5 busy held", ld_busy, 1);
      else        chk("R5 busy falls after 16", ld_busy, 0);
    end
    for (int k = 0; k < 16; k++) mdl[k] = nmap[k];
    if (inject) check_map("R7 R8 loaded map unaffected");
    else        check_map("R5 R6 loaded map order");
    din = 16'($urandom);
    #1 chk("R6 new routing", dout, exp_out(din));
  endtask

  task automatic random_phase(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      din = 16'($urandom);
      host_addr = 4'($urandom_range(15));
      host_wdata = 4'($urandom_range(15));
      host_we = ($urandom_range(3) == 0);
      #1;
      chk("R2 routing", dout, exp_out(din));
      chk("R4 readback", host_rdata, mdl[host_addr]);
      @(posedge clk);
      if (host_we) mdl[host_addr] = host_wdata;
    end
    @(negedge clk);
    host_we = 0;
    #1 chk("R3 write visible", dout, exp_out(din));
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int k = 0; k < 16; k++) mdl[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_map("R1 reset map");
    din = 16'h0001; #1 chk("R1 reset routing one", dout, 16'hFFFF);
    din = 16'hFFFE; #1 chk("R1 reset routing zero", dout, 16'h0000);
    chk("R1 idle after reset", ld_busy, 0);

    // directed: write output 15 from input 15, output 0 from input 9
    @(negedge clk);
    host_we = 1; host_addr = 4'd15; host_wdata = 4'd15;
    @(negedge clk);
    host_addr = 4'd0; host_wdata = 4'd9;
    @(negedge clk);
    host_we = 0; mdl[15] = 4'd15; mdl[0] = 4'd9;
    din = 16'h8200;
    #1 chk("R3 directed write", dout, exp_out(din));
    host_addr = 4'd15; #1 chk("R4 directed readback", host_rdata, 4'd15);

    random_phase(300);
    do_load(0);
    random_phase(100);
    do_load(1);
    random_phase(100);
    do_load(0);
    random_phase(50);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule